// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block holds one address reservation for each hardware context. Software uses these reservations to build atomic read-modify-write sequences. A load-linked request from a context records the 16-byte granule that holds the target address and arms that context's reservation. A later store-conditional from the same context is checked against the armed granule within the same cycle. The block then tells the memory pipeline whether the store may be issued and which result code the store-conditional writes back to its destination register.

An uncacheable store-conditional skips the check entirely. It is always issued and reports a distinct bypass code. An external invalidate disarms the reservation of one context. Typical sources are a coherence hit on the reserved granule or a context switch. To detect livelock, each context counts its consecutive failed store-conditionals. The block pulses a warning on every tenth consecutive failure and sets a sticky fatal flag once 5000 consecutive failures have been reached.

Top module: `llsc_monitor`

## Requirements
- R1: Address bits [3:0] are ignored. A reservation and its check cover the aligned 16-byte granule given by address bits [ADDR_W-1:4].
- R2: A load-linked request (`req_valid_i`=1, `req_sc_i`=0) stores the granule of `req_addr_i` for context `req_ctx_i` and arms that context's reservation. A store-conditional in any later cycle sees the new reservation.
- R3: A cacheable store-conditional whose context is armed and whose granule matches the stored one succeeds. In the same cycle it drives `sc_issue_o`=1 and `sc_result_o`=1. It also resets that context's consecutive-failure count to zero.
- R4: A cacheable store-conditional that fails drives `sc_issue_o`=0 and `sc_result_o`=0 in the same cycle. It also disarms that context's reservation.
- R5: An uncacheable store-conditional drives `sc_issue_o`=1, `sc_result_o`=2 and `sc_cause_o`=0. It leaves that context's reservation and failure count unchanged.
- R6: `sc_cause_o` is 1 when a cacheable store-conditional fails because its context is not armed. It is 2 when the context is armed but the granule differs. It is 0 in every other case. When both conditions apply, the value is 1.
- R7: `warn_o[c]` is high for exactly one cycle. That cycle is the one after a failed cacheable store-conditional of context c that brings c's consecutive-failure count to a nonzero multiple of 10.
- R8: `fatal_o[c]` rises in the cycle after context c's 5000th consecutive failure. It stays high until reset.
- R9: `inv_i` disarms the reservation of context `inv_ctx_i`. If a load-linked request to the same context arrives in the same cycle, the load-linked request wins and the reservation is armed.
- R10: Each context's reservation, failure count, warning and fatal flag are independent of all other contexts.
- R11: Reset disarms every reservation, clears every stored granule and failure count, and drives `warn_o` and `fatal_o` to zero. When no store-conditional is presented, `sc_issue_o`, `sc_result_o` and `sc_cause_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_sc_i | input | 1 | 1 = store-conditional, 0 = load-linked |
| req_ctx_i | input | CTX_W | Requesting hardware context |
| req_addr_i | input | ADDR_W | Physical address of the request |
| req_uncached_i | input | 1 | Request targets uncacheable memory |
| inv_i | input | 1 | Invalidate strobe |
| inv_ctx_i | input | CTX_W | Context whose reservation is invalidated |
| sc_issue_o | output | 1 | Store-conditional may be issued to memory |
| sc_result_o | output | 2 | Write-back code: 0 fail, 1 pass, 2 bypass |
| sc_cause_o | output | 2 | Failure cause: 0 none, 1 not armed, 2 granule mismatch |
| warn_o | output | NUM_CTX | One-cycle livelock warning per context |
| fatal_o | output | NUM_CTX | Sticky livelock fatal flag per context |

## Verification
A reservation flag or granule register holding the wrong value is exposed by the very next store-conditional of that context. That store's issue, result and cause are combinational, so they are wrong in the same cycle. A drifting failure counter does not show up at once. It surfaces at the next tenth failure, as a missing or misplaced warning pulse one cycle after that failure. A counter that is off by a little is exposed only at the fatal threshold, so the bench drives one context through a full run of 5000 failures. It checks the warning after every step and checks the fatal edge at the exact count.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [1:0] {
    SC_RES_FAIL   = 2'd0,
    SC_RES_PASS   = 2'd1,
    SC_RES_BYPASS = 2'd2
  } sc_result_e;

  typedef enum logic [1:0] {
    SC_WHY_NONE     = 2'd0,
    SC_WHY_UNARMED  = 2'd1,
    SC_WHY_MISMATCH = 2'd2
  } sc_cause_e;

  typedef struct packed {
    logic is_ll;
    logic is_sc_cached;
    logic is_sc_uncached;
  } req_kind_t;

endpackage

// File: rtl/llsc_rsv_slot.sv
// One context's reservation: arm flag and stored granule.
module llsc_rsv_slot #(
  parameter int GRAN_W = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [GRAN_W-1:0] gran_i,
  output logic              armed_o,
  output logic              match_o
);

  logic              armed_q;
  logic [GRAN_W-1:0] gran_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      gran_q  <= '0;
    end else if (set_i) begin
      armed_q <= 1'b1;
      gran_q  <= gran_i;
    end else if (clr_i) begin
      armed_q <= 1'b0;
    end
  end

  assign armed_o = armed_q;
  assign match_o = (gran_q == gran_i);

endmodule

// File: rtl/llsc_fail_ctr.sv
// Consecutive-failure counter with periodic warning and sticky fatal.
module llsc_fail_ctr #(
  parameter int WARN_PERIOD = 10,
  parameter int FATAL_COUNT = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fail_i,
  input  logic pass_i,
  output logic warn_o,
  output logic fatal_o
);

  localparam int CNT_W = $clog2(FATAL_COUNT + 1);
  localparam int MOD_W = $clog2(WARN_PERIOD);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FATAL_COUNT);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FATAL_COUNT - 1);
  localparam logic [MOD_W-1:0] MOD_LAST = MOD_W'(WARN_PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [MOD_W-1:0] mod_q;
  logic             warn_q;
  logic             fatal_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      mod_q   <= '0;
      warn_q  <= 1'b0;
      fatal_q <= 1'b0;
    end else begin
      warn_q <= fail_i && (mod_q == MOD_LAST);
      if (fail_i) begin
        // saturate so the fatal threshold cannot be crossed twice
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        mod_q <= (mod_q == MOD_LAST) ? '0 : mod_q + 1'b1;
        if (cnt_q == CNT_LAST) fatal_q <= 1'b1;
      end else if (pass_i) begin
        cnt_q <= '0;
        mod_q <= '0;
      end
    end
  end

  assign warn_o  = warn_q;
  assign fatal_o = fatal_q;

endmodule

// File: rtl/llsc_sc_decide.sv
// Same-cycle store-conditional verdict.
module llsc_sc_decide
  import llsc_pkg::*;
(
  input  req_kind_t  kind_i,
  input  logic       armed_i,
  input  logic       match_i,
  output logic       issue_o,
  output sc_result_e result_o,
  output sc_cause_e  cause_o,
  output logic       fail_o,
  output logic       pass_o
);

  always_comb begin
    issue_o  = 1'b0;
    result_o = SC_RES_FAIL;
    cause_o  = SC_WHY_NONE;
    fail_o   = 1'b0;
    pass_o   = 1'b0;
    if (kind_i.is_sc_uncached) begin
      issue_o  = 1'b1;
      result_o = SC_RES_BYPASS;
    end else if (kind_i.is_sc_cached) begin
      if (!armed_i) begin
        cause_o = SC_WHY_UNARMED;
        fail_o  = 1'b1;
      end else if (!match_i) begin
        cause_o = SC_WHY_MISMATCH;
        fail_o  = 1'b1;
      end else begin
        issue_o  = 1'b1;
        result_o = SC_RES_PASS;
        pass_o   = 1'b1;
      end
    end
  end

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int NUM_CTX     = 4,
  parameter int ADDR_W      = 32,
  parameter int GRAN_BITS   = 4,
  parameter int WARN_PERIOD = 10,
  parameter int FATAL_COUNT = 5000,
  localparam int CTX_W      = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic               req_sc_i,
  input  logic [CTX_W-1:0]   req_ctx_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic               req_uncached_i,
  input  logic               inv_i,
  input  logic [CTX_W-1:0]   inv_ctx_i,
  output logic               sc_issue_o,
  output logic [1:0]         sc_result_o,
  output logic [1:0]         sc_cause_o,
  output logic [NUM_CTX-1:0] warn_o,
  output logic [NUM_CTX-1:0] fatal_o
);

  localparam int GRAN_W = ADDR_W - GRAN_BITS;

  req_kind_t         kind;
  logic [GRAN_W-1:0] req_gran;
  logic              unused_low;

  logic [NUM_CTX-1:0] armed_vec;
  logic [NUM_CTX-1:0] match_vec;
  logic               sel_armed;
  logic               sel_match;

  logic       sc_fail;
  logic       sc_pass;
  sc_result_e result;
  sc_cause_e  cause;

  assign kind.is_ll          = req_valid_i && !req_sc_i;
  assign kind.is_sc_cached   = req_valid_i && req_sc_i && !req_uncached_i;
  assign kind.is_sc_uncached = req_valid_i && req_sc_i && req_uncached_i;

  assign req_gran   = req_addr_i[ADDR_W-1:GRAN_BITS];
  assign unused_low = ^req_addr_i[GRAN_BITS-1:0];

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
    logic sel_req;
    logic sel_inv;

    assign sel_req = (req_ctx_i == CTX_W'(g));
    assign sel_inv = inv_i && (inv_ctx_i == CTX_W'(g));

    llsc_rsv_slot #(
      .GRAN_W (GRAN_W)
    ) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (kind.is_ll && sel_req),
      .clr_i   (sel_inv || (sc_fail && sel_req)),
      .gran_i  (req_gran),
      .armed_o (armed_vec[g]),
      .match_o (match_vec[g])
    );

    llsc_fail_ctr #(
      .WARN_PERIOD (WARN_PERIOD),
      .FATAL_COUNT (FATAL_COUNT)
    ) u_ctr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .fail_i  (sc_fail && sel_req),
      .pass_i  (sc_pass && sel_req),
      .warn_o  (warn_o[g]),
      .fatal_o (fatal_o[g])
    );
  end

  assign sel_armed = armed_vec[req_ctx_i];
  assign sel_match = match_vec[req_ctx_i];

  llsc_sc_decide u_decide (
    .kind_i   (kind),
    .armed_i  (sel_armed),
    .match_i  (sel_match),
    .issue_o  (sc_issue_o),
    .result_o (result),
    .cause_o  (cause),
    .fail_o   (sc_fail),
    .pass_o   (sc_pass)
  );

  assign sc_result_o = result;
  assign sc_cause_o  = cause;

endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int NUM_CTX   = 4,
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 4,
  parameter int CTX_W     = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic               req_sc_i,
  input logic [CTX_W-1:0]   req_ctx_i,
  input logic [ADDR_W-1:0]  req_addr_i,
  input logic               req_uncached_i,
  input logic               sc_issue_o,
  input logic [1:0]         sc_result_o,
  input logic [1:0]         sc_cause_o,
  input logic [NUM_CTX-1:0] warn_o,
  input logic [NUM_CTX-1:0] fatal_o
);

  logic sc_cached;
  assign sc_cached = req_valid_i && req_sc_i && !req_uncached_i;

  // R4: a failed store-conditional is never issued
  p_fail_no_issue_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_cached && sc_result_o == 2'd0) |-> !sc_issue_o);

  // R5: uncacheable store-conditional bypasses with code 2
  p_bypass_code_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_sc_i && req_uncached_i) |->
      (sc_issue_o && sc_result_o == 2'd2 && sc_cause_o == 2'd0));

  // R6: a cause is reported only with a failing cacheable store-conditional
  p_cause_on_fail_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_cause_o != 2'd0) |-> (sc_cached && sc_result_o == 2'd0));

  // R3: load-linked immediately followed by a same-granule store-conditional passes
  p_ll_sc_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_cached && $past(req_valid_i && !req_sc_i) && req_ctx_i == $past(req_ctx_i)
     && req_addr_i[ADDR_W-1:GRAN_BITS] == $past(req_addr_i[ADDR_W-1:GRAN_BITS]))
    |-> (sc_result_o == 2'd1 && sc_issue_o));

  // R7: a warning follows a failed cacheable store-conditional of that context
  p_warn_after_fail_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warn_o != '0) |-> ($past(sc_cached && sc_result_o == 2'd0)
                        && warn_o == (NUM_CTX'(1) << $past(req_ctx_i))));

  // R8: fatal flags never drop
  p_fatal_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((fatal_o & $past(fatal_o)) == $past(fatal_o)));

endmodule

bind llsc_monitor llsc_monitor_chk #(
  .NUM_CTX   (NUM_CTX),
  .ADDR_W    (ADDR_W),
  .GRAN_BITS (GRAN_BITS),
  .CTX_W     (CTX_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_sc_i       (req_sc_i),
  .req_ctx_i      (req_ctx_i),
  .req_addr_i     (req_addr_i),
  .req_uncached_i (req_uncached_i),
  .sc_issue_o     (sc_issue_o),
  .sc_result_o    (sc_result_o),
  .sc_cause_o     (sc_cause_o),
  .warn_o         (warn_o),
  .fatal_o        (fatal_o)
);

// File: tb/tb_llsc_monitor.sv
`timescale 1ns/1ps
module tb_llsc_monitor;

  localparam int NC = 4;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic          req_sc_i = 1'b0;
  logic [1:0]    req_ctx_i = '0;
  logic [AW-1:0] req_addr_i = '0;
  logic          req_uncached_i = 1'b0;
  logic          inv_i = 1'b0;
  logic [1:0]    inv_ctx_i = '0;
  logic          sc_issue_o;
  logic [1:0]    sc_result_o;
  logic [1:0]    sc_cause_o;
  logic [NC-1:0] warn_o;
  logic [NC-1:0] fatal_o;

  always #10 clk = ~clk;

  llsc_monitor dut (
    .clk_i (clk), .rst_ni (rst_ni),
    .req_valid_i (req_valid_i), .req_sc_i (req_sc_i), .req_ctx_i (req_ctx_i),
    .req_addr_i (req_addr_i), .req_uncached_i (req_uncached_i),
    .inv_i (inv_i), .inv_ctx_i (inv_ctx_i),
    .sc_issue_o (sc_issue_o), .sc_result_o (sc_result_o), .sc_cause_o (sc_cause_o),
    .warn_o (warn_o), .fatal_o (fatal_o)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  bit            m_flag  [NC];
  logic [AW-5:0] m_gran  [NC];
  int            m_cons  [NC];
  bit            m_fatal [NC];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] exp_verdict(bit v, bit sc, int ctx, logic [AW-1:0] a, bit unc);
    // {issue, result[1:0]} packed with cause in a second call is clumsy; return issue,result
    if (!(v && sc)) return 4'b0000;
    if (unc) return {1'b1, 2'd2, 1'b0};
    if (!m_flag[ctx]) return {1'b0, 2'd0, 1'b0};
    if (m_gran[ctx] != a[AW-1:4]) return {1'b0, 2'd0, 1'b0};
    return {1'b1, 2'd1, 1'b0};
  endfunction

  function automatic int exp_cause(bit v, bit sc, int ctx, logic [AW-1:0] a, bit unc);
    if (!(v && sc) || unc) return 0;
    if (!m_flag[ctx]) return 1;
    if (m_gran[ctx] != a[AW-1:4]) return 2;
    return 0;
  endfunction

  // Called at a negedge; returns at the following negedge.
  task automatic step(input bit v, input bit sc, input int ctx, input logic [AW-1:0] a,
                      input bit unc, input bit inv, input int ictx, input string tag);
    logic [3:0]    vd;
    int            cz;
    logic [NC-1:0] ew;
    logic [NC-1:0] ef;
    req_valid_i = v; req_sc_i = sc; req_ctx_i = 2'(ctx); req_addr_i = a;
    req_uncached_i = unc; inv_i = inv; inv_ctx_i = 2'(ictx);
    #2;
    vd = exp_verdict(v, sc, ctx, a, unc);
    cz = exp_cause(v, sc, ctx, a, unc);
    chk(sc_issue_o == vd[3], {tag, " issue"}, int'(sc_issue_o), int'(vd[3]));
    chk(sc_result_o == vd[2:1], {tag, " result"}, int'(sc_result_o), int'(vd[2:1]));
    chk(int'(sc_cause_o) == cz, {tag, " cause R6"}, int'(sc_cause_o), cz);
    @(posedge clk);
    ew = '0;
    if (inv) m_flag[ictx] = 1'b0;
    if (v && !sc) begin m_flag[ctx] = 1'b1; m_gran[ctx] = a[AW-1:4]; end
    if (v && sc && !unc) begin
      if (vd[2:1] == 2'd1) m_cons[ctx] = 0;
      else begin
        m_flag[ctx] = 1'b0;
        m_cons[ctx]++;
        if (m_cons[ctx] % 10 == 0) ew[ctx] = 1'b1;
        if (m_cons[ctx] == 5000) m_fatal[ctx] = 1'b1;
      end
    end
    for (int i = 0; i < NC; i++) ef[i] = m_fatal[i];
    @(negedge clk);
    req_valid_i = 1'b0; inv_i = 1'b0;
    chk(warn_o == ew, {tag, " warn R7"}, int'(warn_o), int'(ew));
    chk(fatal_o == ef, {tag, " fatal R8"}, int'(fatal_o), int'(ef));
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < NC; i++) begin
      m_flag[i] = 0; m_gran[i] = '0; m_cons[i] = 0; m_fatal[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(warn_o == '0 && fatal_o == '0, "R11 reset flags", int'({warn_o, fatal_o}), 0);
    chk(sc_issue_o == 0 && sc_result_o == 0 && sc_cause_o == 0, "R11 idle outputs",
        int'({sc_issue_o, sc_result_o, sc_cause_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R11: nothing armed after reset -> cause 1
    step(1, 1, 0, 32'h0000_1000, 0, 0, 0, "R11 sc after reset");
    // R2 R3 R1: arm, then pass with different low bits
    step(1, 0, 0, 32'h0000_2004, 0, 0, 0, "R2 ll");
    step(1, 1, 0, 32'h0000_200C, 0, 0, 0, "R3 R1 pass same granule");
    // R4 R6: mismatch, then unarmed
    step(1, 0, 1, 32'h0000_3000, 0, 0, 0, "R2 ll ctx1");
    step(1, 1, 1, 32'h0000_3010, 0, 0, 0, "R4 R6 mismatch");
    step(1, 1, 1, 32'h0000_3000, 0, 0, 0, "R4 R6 cleared after fail");
    // R9: invalidate vs load-linked same cycle
    step(1, 0, 2, 32'h0000_4000, 0, 1, 2, "R9 ll wins over inv");
    step(1, 1, 2, 32'h0000_4008, 0, 0, 0, "R9 armed after tie");
    step(1, 0, 2, 32'h0000_4000, 0, 0, 0, "R9 rearm");
    step(0, 0, 0, 32'h0, 0, 1, 2, "R9 inv alone");
    step(1, 1, 2, 32'h0000_4000, 0, 0, 0, "R9 disarmed");
    // R5: bypass leaves reservation intact
    step(1, 0, 3, 32'h0000_5000, 0, 0, 0, "R5 ll");
    step(1, 1, 3, 32'h0000_6000, 1, 0, 0, "R5 bypass");
    step(1, 1, 3, 32'h0000_5000, 0, 0, 0, "R5 reservation kept");
    // R10: ctx independence
    step(1, 0, 0, 32'h0000_7000, 0, 0, 0, "R10 ll ctx0");
    step(1, 0, 1, 32'h0000_8000, 0, 0, 0, "R10 ll ctx1");
    step(0, 0, 0, 32'h0, 0, 1, 1, "R10 inv ctx1");
    step(1, 1, 0, 32'h0000_7000, 0, 0, 0, "R10 ctx0 unaffected");

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      int r  = $urandom_range(0, 99);
      int c  = $urandom_range(0, NC - 1);
      logic [AW-1:0] a = 32'h0000_9000 + 32'($urandom_range(0, 47));
      bit iv = ($urandom_range(0, 9) == 0);
      int ic = $urandom_range(0, NC - 1);
      if (r < 35)      step(1, 0, c, a, 0, iv, ic, "R2 R9 rand ll");
      else if (r < 85) step(1, 1, c, a, 0, iv, ic, "R3 R4 rand sc");
      else if (r < 92) step(1, 1, c, a, 1, iv, ic, "R5 rand bypass");
      else             step(0, 0, 0, a, 0, iv, ic, "R10 rand idle");
    end

    // R7 R8: long failure run on ctx 3
    step(0, 0, 0, 32'h0, 0, 1, 3, "R8 inv before run");
    for (int n = 0; n < 5005; n++)
      step(1, 1, 3, 32'h0000_A000, 0, 0, 0, "R7 R8 fail run");
    // R3: pass clears the count, fatal stays
    step(1, 0, 3, 32'h0000_A000, 0, 0, 0, "R3 ll after run");
    step(1, 1, 3, 32'h0000_A000, 0, 0, 0, "R3 R8 pass after fatal");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule